// File: doc/BRIEF.md
# Triple Buffer Exchange Controller

This block manages the segment pointers of two triple-buffer sets used for cyclic data exchange between a bus protocol engine and an application. The input-data set holds the reply pointers. The protocol side transmits from its D buffer, the application fills its U buffer, and the N buffer passes finished data between them. The output-data set holds the indication pointers. The protocol side writes received outputs into D, the application reads U, and N again carries the handover.

Every handover is an atomic swap of two pointers. A single valid flag tracks each handover: the producing side sets it and the consuming side clears it. The two flags appear at fixed bit positions of an access flag byte that neighbouring logic decodes.

The block also holds the programmed buffer lengths and the response priority code. It refuses values that are out of range.

Top module: `tbx_exchange_ctrl`

## Requirements
- R1: A synchronous reset loads every pointer from its configuration input. It also clears both valid flags, sets both lengths to 0 and sets the response status to 08h.
- R2: An application input swap exchanges reply pointers U and N and sets the reply valid flag (acc_flags bit 6).
- R3: A protocol reply fetch while bit 6 is set exchanges reply pointers D and N and clears bit 6. The new D is visible the cycle after the request.
- R4: A protocol reply fetch while bit 6 is clear changes nothing, so the same D buffer is sent again.
- R5: A protocol receive-done swap exchanges indication pointers D and N and sets the indication valid flag (acc_flags bit 7).
- R6: An application output fetch while bit 7 is set exchanges indication pointers N and U and clears bit 7. While bit 7 is clear the fetch changes nothing.
- R7: When both sides request a swap of the same set in one cycle, the protocol operation is applied first. The application operation is applied in the following cycle.
- R8: The three pointers of each set always stay distinct.
- R9: A length write of 0 to 246 is stored. A larger value is ignored and the previous length is kept.
- R10: A status write of 08h (low priority) or 0Ah (high priority) is stored. Any other value is ignored.
- R11: acc_flags bits 5 to 0 always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rep_d | input | 8 | Reset value of reply pointer D |
| cfg_rep_n | input | 8 | Reset value of reply pointer N |
| cfg_rep_u | input | 8 | Reset value of reply pointer U |
| cfg_ind_d | input | 8 | Reset value of indication pointer D |
| cfg_ind_n | input | 8 | Reset value of indication pointer N |
| cfg_ind_u | input | 8 | Reset value of indication pointer U |
| app_rep_swap | input | 1 | Application has filled reply U; swap U and N |
| prot_rep_fetch | input | 1 | Protocol requests fresh input data (D and N) |
| prot_ind_swap | input | 1 | Protocol finished a clean receive into indication D |
| app_ind_fetch | input | 1 | Application requests fresh output data (N and U) |
| len_wr | input | 1 | Length write strobe |
| len_sel | input | 1 | 0 selects the reply length, 1 selects the indication length |
| len_wdata | input | 8 | Length write value |
| stat_wr | input | 1 | Response status write strobe |
| stat_wdata | input | 8 | Response status write value |
| rep_d | output | 8 | Reply pointer D |
| rep_n | output | 8 | Reply pointer N |
| rep_u | output | 8 | Reply pointer U |
| ind_d | output | 8 | Indication pointer D |
| ind_n | output | 8 | Indication pointer N |
| ind_u | output | 8 | Indication pointer U |
| acc_flags | output | 8 | Bit 7 is the indication valid flag, bit 6 is the reply valid flag, all other bits are 0 |
| rep_len | output | 8 | Reply buffer length |
| ind_len | output | 8 | Indication buffer length |
| resp_status | output | 8 | Response priority code |

## Verification
The bench builds the block with its default parameters: 8-bit pointers and lengths, and a maximum length of 246. With these values the limit of 246 and the first rejected value of 247 can both be reached directly through the 8-bit write port. The pointer table walks both sets through every swap. It issues fetches against a clear flag, same-cycle collisions on each set separately and on both sets at once, and the deferred application operation that follows each collision. This brings the ordering rule and the distinctness of the pointers within reach.

// File: rtl/tbx_pkg.sv
package tbx_pkg;

    localparam int PTR_W = 8;

    typedef logic [PTR_W-1:0] seg_ptr_t;

    typedef struct packed {
        seg_ptr_t d;
        seg_ptr_t n;
        seg_ptr_t u;
    } ptr_set_t;

    localparam logic [7:0] STAT_LOW  = 8'h08;
    localparam logic [7:0] STAT_HIGH = 8'h0A;

    function automatic logic len_ok(input logic [7:0] v, input int unsigned max_len);
        return (32'(v) <= max_len);
    endfunction

    function automatic logic status_ok(input logic [7:0] v);
        return (v == STAT_LOW) || (v == STAT_HIGH);
    endfunction

    function automatic logic set_distinct(input ptr_set_t s);
        return (s.d != s.n) && (s.n != s.u) && (s.d != s.u);
    endfunction

endpackage

// File: rtl/tbx_triple_set.sv
module tbx_triple_set
    import tbx_pkg::*;
#(
    parameter bit PROT_IS_PRODUCER = 1'b0
) (
    input  logic     clk,
    input  logic     rst,
    input  ptr_set_t cfg,
    input  logic     prot_req,
    input  logic     app_req,
    output ptr_set_t ptrs,
    output logic     n_valid
);

    logic app_pend;
    logic app_go;

    // Protocol side always wins; the application request waits one cycle.
    assign app_go = (app_req | app_pend) & ~prot_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptrs     <= cfg;
            n_valid  <= 1'b0;
            app_pend <= 1'b0;
        end else begin
            app_pend <= (app_req | app_pend) & prot_req;
            if (prot_req) begin
                if (PROT_IS_PRODUCER) begin
                    ptrs.d  <= ptrs.n;
                    ptrs.n  <= ptrs.d;
                    n_valid <= 1'b1;
                end else if (n_valid) begin
                    ptrs.d  <= ptrs.n;
                    ptrs.n  <= ptrs.d;
                    n_valid <= 1'b0;
                end
            end else if (app_go) begin
                if (!PROT_IS_PRODUCER) begin
                    ptrs.u  <= ptrs.n;
                    ptrs.n  <= ptrs.u;
                    n_valid <= 1'b1;
                end else if (n_valid) begin
                    ptrs.u  <= ptrs.n;
                    ptrs.n  <= ptrs.u;
                    n_valid <= 1'b0;
                end
            end
        end
    end

    assert_reset_load_R1: assert property (@(posedge clk)
        rst |=> (!n_valid && ptrs == $past(cfg)));

    assert_ptrs_distinct_R8: assert property (@(posedge clk) disable iff (rst)
        set_distinct(ptrs) |=> set_distinct(ptrs));

    assert_collision_defer_R7: assert property (@(posedge clk) disable iff (rst)
        (prot_req && app_req) |=> $stable(ptrs.u));

    generate
        if (PROT_IS_PRODUCER) begin : g_prot_prod
            assert_prot_sets_valid_R5: assert property (@(posedge clk) disable iff (rst)
                prot_req |=> n_valid);
            assert_app_idle_fetch_R6: assert property (@(posedge clk) disable iff (rst)
                (app_go && !n_valid) |=> ($stable(ptrs) && !n_valid));
        end else begin : g_app_prod
            assert_app_sets_valid_R2: assert property (@(posedge clk) disable iff (rst)
                app_go |=> n_valid);
            assert_prot_resend_R4: assert property (@(posedge clk) disable iff (rst)
                (prot_req && !n_valid) |=> $stable(ptrs.d));
            assert_prot_clears_R3: assert property (@(posedge clk) disable iff (rst)
                (prot_req && n_valid) |=> (!n_valid && ptrs.d == $past(ptrs.n)));
        end
    endgenerate

endmodule

// File: rtl/tbx_cfg_regs.sv
module tbx_cfg_regs
    import tbx_pkg::*;
#(
    parameter int unsigned MAX_LEN = 246,
    parameter int unsigned LEN_W   = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             len_wr,
    input  logic             len_sel,
    input  logic [LEN_W-1:0] len_wdata,
    input  logic             stat_wr,
    input  logic [7:0]       stat_wdata,
    output logic [LEN_W-1:0] rep_len,
    output logic [LEN_W-1:0] ind_len,
    output logic [7:0]       resp_status
);

    logic len_accept;
    assign len_accept = len_wr && (32'(len_wdata) <= MAX_LEN);

    always_ff @(posedge clk) begin
        if (rst) begin
            rep_len     <= '0;
            ind_len     <= '0;
            resp_status <= STAT_LOW;
        end else begin
            if (len_accept && !len_sel) rep_len <= len_wdata;
            if (len_accept &&  len_sel) ind_len <= len_wdata;
            if (stat_wr && status_ok(stat_wdata)) resp_status <= stat_wdata;
        end
    end

    assert_len_in_range_R9: assert property (@(posedge clk) disable iff (rst)
        (32'(rep_len) <= MAX_LEN) && (32'(ind_len) <= MAX_LEN));

    assert_len_reject_R9: assert property (@(posedge clk) disable iff (rst)
        (len_wr && 32'(len_wdata) > MAX_LEN) |=> ($stable(rep_len) && $stable(ind_len)));

    assert_status_legal_R10: assert property (@(posedge clk) disable iff (rst)
        (resp_status == STAT_LOW) || (resp_status == STAT_HIGH));

endmodule

// File: rtl/tbx_exchange_ctrl.sv
module tbx_exchange_ctrl
    import tbx_pkg::*;
#(
    parameter int unsigned MAX_LEN = 246,
    parameter int unsigned LEN_W   = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       cfg_rep_d,
    input  logic [7:0]       cfg_rep_n,
    input  logic [7:0]       cfg_rep_u,
    input  logic [7:0]       cfg_ind_d,
    input  logic [7:0]       cfg_ind_n,
    input  logic [7:0]       cfg_ind_u,
    input  logic             app_rep_swap,
    input  logic             prot_rep_fetch,
    input  logic             prot_ind_swap,
    input  logic             app_ind_fetch,
    input  logic             len_wr,
    input  logic             len_sel,
    input  logic [LEN_W-1:0] len_wdata,
    input  logic             stat_wr,
    input  logic [7:0]       stat_wdata,
    output logic [7:0]       rep_d,
    output logic [7:0]       rep_n,
    output logic [7:0]       rep_u,
    output logic [7:0]       ind_d,
    output logic [7:0]       ind_n,
    output logic [7:0]       ind_u,
    output logic [7:0]       acc_flags,
    output logic [LEN_W-1:0] rep_len,
    output logic [LEN_W-1:0] ind_len,
    output logic [7:0]       resp_status
);

    localparam int REP_VALID_BIT = 6;
    localparam int IND_VALID_BIT = 7;

    ptr_set_t rep_cfg, ind_cfg, rep_ptrs, ind_ptrs;
    logic     rep_valid, ind_valid;

    assign rep_cfg = '{d: cfg_rep_d, n: cfg_rep_n, u: cfg_rep_u};
    assign ind_cfg = '{d: cfg_ind_d, n: cfg_ind_n, u: cfg_ind_u};

    // Input data: application produces, protocol consumes.
    tbx_triple_set #(.PROT_IS_PRODUCER(1'b0)) rep_set_i (
        .clk(clk), .rst(rst), .cfg(rep_cfg),
        .prot_req(prot_rep_fetch), .app_req(app_rep_swap),
        .ptrs(rep_ptrs), .n_valid(rep_valid)
    );

    // Output data: protocol produces, application consumes.
    tbx_triple_set #(.PROT_IS_PRODUCER(1'b1)) ind_set_i (
        .clk(clk), .rst(rst), .cfg(ind_cfg),
        .prot_req(prot_ind_swap), .app_req(app_ind_fetch),
        .ptrs(ind_ptrs), .n_valid(ind_valid)
    );

    tbx_cfg_regs #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) cfg_regs_i (
        .clk(clk), .rst(rst),
        .len_wr(len_wr), .len_sel(len_sel), .len_wdata(len_wdata),
        .stat_wr(stat_wr), .stat_wdata(stat_wdata),
        .rep_len(rep_len), .ind_len(ind_len), .resp_status(resp_status)
    );

    assign rep_d = rep_ptrs.d;
    assign rep_n = rep_ptrs.n;
    assign rep_u = rep_ptrs.u;
    assign ind_d = ind_ptrs.d;
    assign ind_n = ind_ptrs.n;
    assign ind_u = ind_ptrs.u;

    always_comb begin
        acc_flags                = '0;
        acc_flags[REP_VALID_BIT] = rep_valid;
        acc_flags[IND_VALID_BIT] = ind_valid;
    end

    assert_flags_low_zero_R11: assert property (@(posedge clk) disable iff (rst)
        acc_flags[5:0] == 6'd0);

endmodule

// File: tb/tbx_exchange_ctrl_tb_top.sv
module tbx_exchange_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] cfg_rep_d, cfg_rep_n, cfg_rep_u, cfg_ind_d, cfg_ind_n, cfg_ind_u;
    logic       app_rep_swap, prot_rep_fetch, prot_ind_swap, app_ind_fetch;
    logic       len_wr, len_sel, stat_wr;
    logic [7:0] len_wdata, stat_wdata;
    logic [7:0] rep_d, rep_n, rep_u, ind_d, ind_n, ind_u, acc_flags;
    logic [7:0] rep_len, ind_len, resp_status;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;  // 50 MHz

    tbx_exchange_ctrl dut_i (
        .clk(clk), .rst(rst),
        .cfg_rep_d(cfg_rep_d), .cfg_rep_n(cfg_rep_n), .cfg_rep_u(cfg_rep_u),
        .cfg_ind_d(cfg_ind_d), .cfg_ind_n(cfg_ind_n), .cfg_ind_u(cfg_ind_u),
        .app_rep_swap(app_rep_swap), .prot_rep_fetch(prot_rep_fetch),
        .prot_ind_swap(prot_ind_swap), .app_ind_fetch(app_ind_fetch),
        .len_wr(len_wr), .len_sel(len_sel), .len_wdata(len_wdata),
        .stat_wr(stat_wr), .stat_wdata(stat_wdata),
        .rep_d(rep_d), .rep_n(rep_n), .rep_u(rep_u),
        .ind_d(ind_d), .ind_n(ind_n), .ind_u(ind_u),
        .acc_flags(acc_flags), .rep_len(rep_len), .ind_len(ind_len),
        .resp_status(resp_status)
    );

    typedef struct packed {
        logic       app_rep, prot_rep, prot_ind, app_ind;
        logic [7:0] rd, rn, ru;
        logic [7:0] id, in_, iu;
        logic [7:0] flags;
    } vec_t;

    // Each row: requests for one cycle, then the expected state after that edge.
    localparam vec_t TBL [12] = '{
        '{1'b0,1'b1,1'b0,1'b0, 8'd10,8'd20,8'd30, 8'd40,8'd50,8'd60, 8'h00}, // R4 fetch, flag clear
        '{1'b1,1'b0,1'b0,1'b0, 8'd10,8'd30,8'd20, 8'd40,8'd50,8'd60, 8'h40}, // R2
        '{1'b0,1'b1,1'b0,1'b0, 8'd30,8'd10,8'd20, 8'd40,8'd50,8'd60, 8'h00}, // R3
        '{1'b0,1'b0,1'b0,1'b1, 8'd30,8'd10,8'd20, 8'd40,8'd50,8'd60, 8'h00}, // R6 fetch, flag clear
        '{1'b0,1'b0,1'b1,1'b0, 8'd30,8'd10,8'd20, 8'd50,8'd40,8'd60, 8'h80}, // R5
        '{1'b0,1'b0,1'b0,1'b1, 8'd30,8'd10,8'd20, 8'd50,8'd60,8'd40, 8'h00}, // R6
        '{1'b1,1'b1,1'b0,1'b0, 8'd30,8'd10,8'd20, 8'd50,8'd60,8'd40, 8'h00}, // R7 reply collision
        '{1'b0,1'b0,1'b0,1'b0, 8'd30,8'd20,8'd10, 8'd50,8'd60,8'd40, 8'h40}, // R7 deferred app
        '{1'b0,1'b0,1'b1,1'b1, 8'd30,8'd20,8'd10, 8'd60,8'd50,8'd40, 8'hC0}, // R7 ind collision
        '{1'b0,1'b0,1'b0,1'b0, 8'd30,8'd20,8'd10, 8'd60,8'd40,8'd50, 8'h40}, // R7 deferred app
        '{1'b1,1'b1,1'b1,1'b1, 8'd20,8'd30,8'd10, 8'd40,8'd60,8'd50, 8'h80}, // R7 both sets
        '{1'b0,1'b0,1'b0,1'b0, 8'd20,8'd10,8'd30, 8'd40,8'd50,8'd60, 8'h40}  // R7 deferred both
    };

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_inputs();
        app_rep_swap = 0; prot_rep_fetch = 0; prot_ind_swap = 0; app_ind_fetch = 0;
        len_wr = 0; len_sel = 0; len_wdata = 0; stat_wr = 0; stat_wdata = 0;
    endtask

    task automatic write_len(input logic sel, input logic [7:0] v);
        @(negedge clk);
        len_wr = 1; len_sel = sel; len_wdata = v;
        @(negedge clk);
        clear_inputs();
    endtask

    task automatic write_stat(input logic [7:0] v);
        @(negedge clk);
        stat_wr = 1; stat_wdata = v;
        @(negedge clk);
        clear_inputs();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        clear_inputs();
        cfg_rep_d = 8'd10; cfg_rep_n = 8'd20; cfg_rep_u = 8'd30;
        cfg_ind_d = 8'd40; cfg_ind_n = 8'd50; cfg_ind_u = 8'd60;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        check8("R1 rep_d", rep_d, 8'd10);
        check8("R1 rep_n", rep_n, 8'd20);
        check8("R1 rep_u", rep_u, 8'd30);
        check8("R1 ind_d", ind_d, 8'd40);
        check8("R1 ind_n", ind_n, 8'd50);
        check8("R1 ind_u", ind_u, 8'd60);
        check8("R1 acc_flags", acc_flags, 8'h00);
        check8("R1 rep_len", rep_len, 8'd0);
        check8("R1 ind_len", ind_len, 8'd0);
        check8("R1 resp_status", resp_status, 8'h08);

        // Pointer swap table (R2..R7, R8, R11)
        for (int i = 0; i < 12; i++) begin
            app_rep_swap   = TBL[i].app_rep;
            prot_rep_fetch = TBL[i].prot_rep;
            prot_ind_swap  = TBL[i].prot_ind;
            app_ind_fetch  = TBL[i].app_ind;
            @(negedge clk);
            clear_inputs();
            check8("R2-R7 vector rep_d", rep_d, TBL[i].rd);
            check8("R2-R7 vector rep_n", rep_n, TBL[i].rn);
            check8("R2-R7 vector rep_u", rep_u, TBL[i].ru);
            check8("R2-R7 vector ind_d", ind_d, TBL[i].id);
            check8("R2-R7 vector ind_n", ind_n, TBL[i].in_);
            check8("R2-R7 vector ind_u", ind_u, TBL[i].iu);
            check8("R11 acc_flags", acc_flags, TBL[i].flags);
            check8("R8 rep distinct", 8'((rep_d != rep_n) && (rep_n != rep_u) && (rep_d != rep_u)), 8'd1);
            check8("R8 ind distinct", 8'((ind_d != ind_n) && (ind_n != ind_u) && (ind_d != ind_u)), 8'd1);
        end

        // R9 length limits
        write_len(1'b0, 8'd246);
        check8("R9 rep_len 246 accepted", rep_len, 8'd246);
        write_len(1'b0, 8'd247);
        check8("R9 rep_len 247 ignored", rep_len, 8'd246);
        write_len(1'b1, 8'd100);
        check8("R9 ind_len 100 accepted", ind_len, 8'd100);
        check8("R9 rep_len untouched", rep_len, 8'd246);
        write_len(1'b1, 8'd255);
        check8("R9 ind_len 255 ignored", ind_len, 8'd100);
        write_len(1'b1, 8'd0);
        check8("R9 ind_len 0 accepted", ind_len, 8'd0);

        // R10 status codes
        write_stat(8'h0A);
        check8("R10 status 0A accepted", resp_status, 8'h0A);
        write_stat(8'h09);
        check8("R10 status 09 ignored", resp_status, 8'h0A);
        write_stat(8'h00);
        check8("R10 status 00 ignored", resp_status, 8'h0A);
        write_stat(8'h08);
        check8("R10 status 08 accepted", resp_status, 8'h08);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule